// File: doc/BRIEF.md
# Watchdog Timer and Memory Control Register

This block is an 8-bit control register on a simple microcontroller register bus. It holds a watchdog timer with eight selectable timeouts. The same byte also carries three static controls: a level that allows byte writes to on-chip EEPROM, a level that sends data-memory accesses to the on-chip EEPROM instead of external memory, and a select bit that chooses one of two data pointer banks.

One bit of the register has two roles. Writing a 1 to it is a restart strobe for the watchdog. Reading it returns an EEPROM ready flag: it reads 0 while a programming operation is busy and 1 otherwise. The watchdog counts pulses of a base-tick enable. The timeout is the base tick count shifted left by a 3-bit prescale code. When the count runs out, the block raises a one-cycle reset output and starts counting again.

The watchdog is a three-state machine:
- `WD_OFF`: disabled, with the counter held at zero.
- `WD_RUN`: counting base ticks.
- `WD_BITE`: the one cycle in which the reset output is high.

Its transitions are:
- `OFF→RUN`: the enable bit is set.
- `RUN→OFF` and `BITE→OFF`: the enable bit is clear.
- `RUN→RUN` on restart: a restart write clears the count.
- `RUN→BITE`: the tick that completes the timeout arrives.
- `BITE→RUN`: the enable bit is still set.

Top module: `wdog_memctl`

## Requirements
- R1: After reset, a read at the register address returns 8'h02 (ready flag 1, all other bits 0), and all four outputs are low.
- R2: A write to any address other than `REG_ADDR` changes no field and no output. A read at any other address returns 8'h00.
- R3: Bits 7:5 hold the prescale code. The timeout is `BASE_TICKS << code` base ticks after the count starts. The tick that completes the timeout moves the machine to `WD_BITE`, which drives `wdt_rst_o` high for exactly one cycle. Ticks are not counted in that cycle, and counting then resumes from zero.
- R4: Bit 4 is driven out as the level `ee_wen_o`.
- R5: Bit 3 is driven out as the level `ee_sel_o` (1 routes data-memory accesses to the on-chip EEPROM).
- R6: Bit 2 is driven out as `dp_bank_o` (0 selects pointer bank 0, 1 selects bank 1).
- R7: A read of bit 1 returns the inverse of `ee_busy`.
- R8: A write with bit 1 set restarts the count from zero. A write with bit 1 clear and an unchanged prescale does not restart. The stored strobe bit clears at the next `cyc_stb` and is never read back.
- R9: Bit 0 enables the watchdog. While it is 0, the counter stays at zero and no reset is raised. Enabling starts the count from zero.
- R10: A write that changes the prescale code restarts the count from zero.
- R11: Cycles with `tick_en` low do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| cyc_stb | input | 1 | Instruction-cycle strobe |
| ee_busy | input | 1 | EEPROM programming in progress |
| tick_en | input | 1 | Base tick enable |
| wdt_rst_o | output | 1 | One-cycle watchdog reset |
| ee_sel_o | output | 1 | On-chip EEPROM select |
| ee_wen_o | output | 1 | EEPROM byte-write enable |
| dp_bank_o | output | 1 | Data pointer bank select |

## Verification
The timing is as follows. The level outputs follow in the cycle after the write edge. Read data and the ready flag are combinational in the same cycle.

With `tick_en` held high, a watchdog enabled by a write at edge E fires in the cycle after edge E+L+1, where L is the selected timeout. A restart or prescale-change write at edge K moves that to K+L. Each later timeout comes L+1 cycles after the previous one.

The bench counts clock edges. Its driver pushes the edge number at which each reset pulse is due into a queue. A monitor samples on the falling edge and pops and compares on every pulse. It flags any pulse that is not expected and any due pulse that is missing.

// File: rtl/wdm_pkg.sv
package wdm_pkg;

    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_BITE = 2'd2
    } wd_state_t;

    // bit positions of the control byte, fixed by software's view
    localparam int unsigned B_EN    = 0;
    localparam int unsigned B_KICK  = 1;
    localparam int unsigned B_BANK  = 2;
    localparam int unsigned B_SEL   = 3;
    localparam int unsigned B_WEN   = 4;
    localparam int unsigned B_PS_LO = 5;
    localparam int unsigned PS_W    = 3;

    typedef struct packed {
        logic [PS_W-1:0] presc;
        logic            ee_wen;
        logic            ee_sel;
        logic            dp_bank;
        logic            kick;
        logic            wd_en;
    } ctl_t;

endpackage

// File: rtl/wdm_regs.sv
module wdm_regs
    import wdm_pkg::*;
#(
    parameter logic [7:0] REG_ADDR = 8'h96
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      bus_addr,
    input  logic            bus_we,
    input  logic [7:0]      bus_wdata,
    input  logic            cyc_stb,
    input  logic            ee_busy,
    output logic [7:0]      bus_rdata,
    output logic [PS_W-1:0] presc,
    output logic            wd_en,
    output logic            ee_wen,
    output logic            ee_sel,
    output logic            dp_bank,
    output logic            restart
);

    ctl_t ctl_q;
    logic hit;
    logic wr_hit;
    logic ps_change;
    logic kick_wr;

    assign hit       = (bus_addr == REG_ADDR);
    assign wr_hit    = hit && bus_we;
    assign kick_wr   = wr_hit && bus_wdata[B_KICK];
    assign ps_change = wr_hit && (bus_wdata[B_PS_LO +: PS_W] != ctl_q.presc);
    assign restart   = kick_wr || ps_change;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            if (wr_hit) begin
                ctl_q.presc   <= bus_wdata[B_PS_LO +: PS_W];
                ctl_q.ee_wen  <= bus_wdata[B_WEN];
                ctl_q.ee_sel  <= bus_wdata[B_SEL];
                ctl_q.dp_bank <= bus_wdata[B_BANK];
                ctl_q.wd_en   <= bus_wdata[B_EN];
            end
            if (kick_wr) begin
                ctl_q.kick <= 1'b1;
            end else if (cyc_stb) begin
                ctl_q.kick <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (hit) begin
            bus_rdata[B_PS_LO +: PS_W] = ctl_q.presc;
            bus_rdata[B_WEN]           = ctl_q.ee_wen;
            bus_rdata[B_SEL]           = ctl_q.ee_sel;
            bus_rdata[B_BANK]          = ctl_q.dp_bank;
            bus_rdata[B_KICK]          = ~ee_busy;
            bus_rdata[B_EN]            = ctl_q.wd_en;
        end
    end

    assign presc   = ctl_q.presc;
    assign wd_en   = ctl_q.wd_en;
    assign ee_wen  = ctl_q.ee_wen;
    assign ee_sel  = ctl_q.ee_sel;
    assign dp_bank = ctl_q.dp_bank;

    AST_MISS_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !hit) |=> ({presc, ee_wen, ee_sel, dp_bank, wd_en} ==
                              $past({presc, ee_wen, ee_sel, dp_bank, wd_en}))); // R2

    AST_KICK_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.kick && cyc_stb && !kick_wr) |=> !ctl_q.kick); // R8

endmodule

// File: rtl/wdm_timer.sv
module wdm_timer
    import wdm_pkg::*;
#(
    parameter int unsigned BASE_TICKS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wd_en,
    input  logic [PS_W-1:0] presc,
    input  logic            restart,
    input  logic            tick_en,
    output logic            wdt_rst
);

    localparam int unsigned MAX_SHIFT = (1 << PS_W) - 1;
    localparam int unsigned CNT_W     = $clog2(BASE_TICKS + 1) + MAX_SHIFT;

    wd_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] limit;
    logic             at_end;

    assign limit  = CNT_W'(BASE_TICKS) << presc;
    assign at_end = tick_en && (cnt_q >= limit - CNT_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF:  if (wd_en) state_d = WD_RUN;
            WD_RUN: begin
                if (!wd_en)       state_d = WD_OFF;
                else if (restart) state_d = WD_RUN;
                else if (at_end)  state_d = WD_BITE;
            end
            WD_BITE: state_d = wd_en ? WD_RUN : WD_OFF;
            default: state_d = WD_OFF;
        endcase
    end

    always_comb begin
        cnt_d = cnt_q;
        unique case (state_q)
            WD_RUN: begin
                if (!wd_en || restart || at_end) cnt_d = '0;
                else if (tick_en)                cnt_d = cnt_q + CNT_W'(1);
            end
            default: cnt_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        wdt_rst = (state_q == WD_BITE);
    end

    AST_BITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst); // R3

    AST_BITE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst) |-> ($past(cnt_q) == $past(limit) - CNT_W'(1))); // R3

    AST_OFF_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_en && $past(!wd_en)) |-> (cnt_q == '0 && !wdt_rst)); // R9

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_RUN && wd_en && restart) |=> (cnt_q == '0 && !wdt_rst)); // R10

endmodule

// File: rtl/wdog_memctl.sv
module wdog_memctl
    import wdm_pkg::*;
#(
    parameter logic [7:0]  REG_ADDR   = 8'h96,
    parameter int unsigned BASE_TICKS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_addr,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       cyc_stb,
    input  logic       ee_busy,
    input  logic       tick_en,
    output logic       wdt_rst_o,
    output logic       ee_sel_o,
    output logic       ee_wen_o,
    output logic       dp_bank_o
);

    logic [PS_W-1:0] presc;
    logic            wd_en;
    logic            restart;

    wdm_regs #(.REG_ADDR(REG_ADDR)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .cyc_stb   (cyc_stb),
        .ee_busy   (ee_busy),
        .bus_rdata (bus_rdata),
        .presc     (presc),
        .wd_en     (wd_en),
        .ee_wen    (ee_wen_o),
        .ee_sel    (ee_sel_o),
        .dp_bank   (dp_bank_o),
        .restart   (restart)
    );

    wdm_timer #(.BASE_TICKS(BASE_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wd_en   (wd_en),
        .presc   (presc),
        .restart (restart),
        .tick_en (tick_en),
        .wdt_rst (wdt_rst_o)
    );

    AST_LEVELS_FOLLOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_ADDR) |=>
        ({ee_wen_o, ee_sel_o, dp_bank_o} == $past(bus_wdata[4:2]))); // R4

endmodule

// File: tb/wdog_memctl_tb.sv
module wdog_memctl_tb;

    localparam logic [7:0] ADDR = 8'h96;
    localparam int BASE = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = ADDR;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cyc_stb = 1'b0;
    logic       ee_busy = 1'b0;
    logic       tick_en = 1'b1;
    logic       wdt_rst_o, ee_sel_o, ee_wen_o, dp_bank_o;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int fires = 0;
    int wr_cyc = 0;
    int exp_q[$];

    wdog_memctl #(.REG_ADDR(ADDR), .BASE_TICKS(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cyc_stb(cyc_stb),
        .ee_busy(ee_busy), .tick_en(tick_en), .wdt_rst_o(wdt_rst_o),
        .ee_sel_o(ee_sel_o), .ee_wen_o(ee_wen_o), .dp_bank_o(dp_bank_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) cyc_stb <= (cyc % 4 == 0);

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compare every reset pulse against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (wdt_rst_o) begin
                fires++;
                if (exp_q.size() == 0) begin
                    check("R3 unexpected pulse at edge", cyc, -1);
                end else begin
                    check("R3 pulse edge", cyc, exp_q.pop_front());
                end
            end else if (exp_q.size() != 0 && cyc > exp_q[0]) begin
                check("R3 missing pulse at edge", cyc, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(posedge clk);
        #1;
        wr_cyc = cyc;
        bus_we = 1'b0;
        bus_addr = ADDR;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
        bus_addr = ADDR;
    endtask

    task automatic wait_until(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic expect_at(input int e);
        exp_q.push_back(e);
    endtask

    initial begin
        int v;
        int e;
        int k;
        int f0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(ADDR, v);
        check("R1 reset read", v, 8'h02);
        check("R1 outputs low", {wdt_rst_o, ee_sel_o, ee_wen_o, dp_bank_o}, 0);

        // R4 R5 R6 level bits
        wr(ADDR, 8'h1C);
        @(negedge clk);
        check("R4 ee_wen_o", ee_wen_o, 1);
        check("R5 ee_sel_o", ee_sel_o, 1);
        check("R6 dp_bank_o", dp_bank_o, 1);
        rd(ADDR, v);
        check("R4 readback", v, 8'h1E);
        wr(ADDR, 8'h08);
        @(negedge clk);
        check("R5 sel only", {ee_wen_o, ee_sel_o, dp_bank_o}, 3'b010);

        // R7 ready flag
        ee_busy = 1'b1;
        rd(ADDR, v);
        check("R7 busy reads 0", v, 8'h08);
        ee_busy = 1'b0;
        rd(ADDR, v);
        check("R7 idle reads 1", v, 8'h0A);

        // R2 address decode
        wr(8'h95, 8'hFF);
        @(negedge clk);
        check("R2 outputs unchanged", {ee_wen_o, ee_sel_o, dp_bank_o}, 3'b010);
        rd(ADDR, v);
        check("R2 field unchanged", v, 8'h0A);
        rd(8'h95, v);
        check("R2 other address reads 0", v, 0);
        wr(ADDR, 8'h00);

        // R9 R3 R8: enable at code 0 (limit 3), a rewrite without strobe keeps the count
        wr(ADDR, 8'h01); e = wr_cyc;
        expect_at(e + 4); expect_at(e + 8);
        wait_until(e + 1);
        wr(ADDR, 8'h01);                         // R8 no restart
        wait_until(e + 9);
        wr(ADDR, 8'h00);                         // R9 disable before e+12
        wait_until(e + 40);
        check("R9 no pulse while off", exp_q.size(), 0);

        // R8 strobe at code 2 (limit 12)
        wr(ADDR, 8'h41); e = wr_cyc;
        wait_until(e + 7);
        wr(ADDR, 8'h43); k = wr_cyc;
        expect_at(k + 12);
        rd(ADDR, v);
        check("R8 strobe not read back", v, 8'h43);
        wait_until(k + 14);
        wr(ADDR, 8'h00);
        wait_until(k + 30);

        // R10 prescale change restarts (code 1 -> 0)
        wr(ADDR, 8'h21); e = wr_cyc;
        wait_until(e + 1);
        wr(ADDR, 8'h01); k = wr_cyc;
        expect_at(k + 3);
        wait_until(k + 4);
        wr(ADDR, 8'h00);
        wait_until(k + 20);
        check("R10 queue drained", exp_q.size(), 0);

        // R3 longest code 7 (limit 384)
        wr(ADDR, 8'hE1); e = wr_cyc;
        expect_at(e + 385);
        wait_until(e + 387);
        wr(ADDR, 8'h00);
        wait_until(e + 400);

        // R11 no ticks, no count
        tick_en = 1'b0;
        f0 = fires;
        wr(ADDR, 8'h01); e = wr_cyc;
        wait_until(e + 40);
        check("R11 no pulse without ticks", fires, f0);
        wr(ADDR, 8'h00);
        tick_en = 1'b1;
        wait_until(cyc + 20);

        check("R3 all pulses seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait (cyc > 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule